// File: doc/BRIEF.md
# Fourth-Order Sinc Decimator

This block turns the 1-bit stream from a delta-sigma modulator into signed 24-bit result words. Each accepted bit is taken as +1 or -1 and passed through a cascade of four running-sum stages at the modulator rate. Every 2^DEC_LOG2 accepted bits the last running sum is sampled into four difference stages. The combined response is a fourth-order sinc (boxcar of length R = 2^DEC_LOG2 convolved with itself four times). The full-precision result is rescaled so that a sustained full-scale input corresponds to 2^23, and is then clamped into the 24-bit two's complement range.

Two operating styles are selectable. In one-shot mode every result is computed from a freshly cleared filter: it appears after exactly 4·R accepted bits, and all filter state is wiped on the same edge, so consecutive results never share input history. In free-running mode the filter keeps its history. The first three partial results after a restart are withheld, and a result then follows every R accepted bits. A synchronous restart strobe clears the filter and its counters in either mode.

Top module: `sinc4_decim`

## Requirements
- R1: While reset is asserted and on the first cycle after, `res_valid` is 0 and `res_data` is 0x000000.
- R2: An input bit of 1 counts as +1 and a bit of 0 counts as -1. The full-precision result equals the sum over k of h[k]·x[n-k], where h holds the coefficients of the fourth power of a length-R boxcar and samples before the start of the conversion count as zero.
- R3: In one-shot mode (`run_mode` = 0) `res_valid` rises on the cycle after the 4·R-th accepted bit, counted since the last restart or the last result. The following conversion starts from cleared state.
- R4: In free-running mode (`run_mode` = 1) the first result follows the 4·R-th accepted bit after a restart. Later results follow every further R accepted bits and are computed over the continuing history.
- R5: A cycle with `mod_ce` low takes no sample. `mod_bit` is ignored on that cycle and no count advances.
- R6: `restart` clears every filter stage and count, and wins over `mod_ce` on the same cycle. The cycle after it has `res_valid` low.
- R7: The full-precision value v is scaled to v·2^(23-4·DEC_LOG2), using an arithmetic right shift when the exponent is negative. An all-zero input conversion therefore gives exactly 0x800000.
- R8: A scaled result above 0x7FFFFF is clamped to 0x7FFFFF and one below -2^23 is clamped to 0x800000. An all-ones conversion gives 0x7FFFFF.
- R9: `res_valid` is high for a single cycle per result. `res_data` changes only on a cycle where `res_valid` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_ce | input | 1 | High on cycles that carry a modulator bit |
| mod_bit | input | 1 | Modulator bit, 1 = +1, 0 = -1 |
| run_mode | input | 1 | 0 = one-shot, 1 = free-running |
| restart | input | 1 | Synchronous clear of filter and counters |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 24 | Two's complement result |

## Verification
The bench builds the block with DEC_LOG2 = 2, so R = 4 and a one-shot conversion spans 16 bits, of which only the last 13 carry weight. At that size every weighted pattern (8192 of them) can be pushed through back to back. The sweep covers each coefficient, both saturation ends and the exact negative full scale, with each expected word taken from a convolution computed in the bench. The short window also makes it cheap to check free-running cadence over many results, gaps in `mod_ce`, and a restart in the middle of a conversion.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;
    typedef enum logic {
        RUN_ONESHOT = 1'b0,
        RUN_FREE    = 1'b1
    } run_mode_e;
endpackage

// File: rtl/sinc4_integ.sv
// Cascade of running sums at the modulator rate; wraparound arithmetic.
module sinc4_integ #(
    parameter int ORDER = 4,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic         bit_in,
    output logic [W-1:0] tail_nx
);
    typedef struct packed {
        logic [ORDER-1:0][W-1:0] acc;
    } integ_st_t;

    integ_st_t    st_q, st_d;
    logic [W-1:0] nx [ORDER];

    always_comb begin
        nx[0] = st_q.acc[0] + (bit_in ? W'(1) : {W{1'b1}});
        for (int k = 1; k < ORDER; k++) begin
            nx[k] = st_q.acc[k] + nx[k-1];
        end
        st_d = st_q;
        if (clr) begin
            st_d.acc = '0;
        end else if (step) begin
            for (int k = 0; k < ORDER; k++) begin
                st_d.acc[k] = nx[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tail_nx = nx[ORDER-1];
endmodule

// File: rtl/sinc4_comb.sv
// Difference stages at the decimated rate; output is combinational.
module sinc4_comb #(
    parameter int ORDER = 4,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [ORDER-1:0][W-1:0] dly;
    } comb_st_t;

    comb_st_t     st_q, st_d;
    logic [W-1:0] stage [ORDER+1];

    always_comb begin
        stage[0] = din;
        for (int k = 0; k < ORDER; k++) begin
            stage[k+1] = stage[k] - st_q.dly[k];
        end
        st_d = st_q;
        if (clr) begin
            st_d.dly = '0;
        end else if (load) begin
            for (int k = 0; k < ORDER; k++) begin
                st_d.dly[k] = stage[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = stage[ORDER];
endmodule

// File: rtl/sinc4_fmt.sv
// Rescale full-precision value so that 2^FS_LOG2 maps to 2^(OUT_W-1), then clamp.
module sinc4_fmt #(
    parameter int W       = 10,
    parameter int FS_LOG2 = 8,
    parameter int OUT_W   = 24
) (
    input  logic [W-1:0]     din,
    output logic [OUT_W-1:0] dout
);
    localparam int SHR = FS_LOG2 - (OUT_W - 1);
    localparam int LSH = (SHR < 0) ? -SHR : 0;
    localparam int RSH = (SHR > 0) ? SHR : 0;
    localparam int XW  = W + LSH;

    logic signed [XW-1:0] wide;

    generate
        if (LSH > 0) begin : g_up
            assign wide = $signed({{LSH{din[W-1]}}, din}) <<< LSH;
        end else begin : g_down
            assign wide = $signed(din) >>> RSH;
        end
    endgenerate

    logic [XW-OUT_W:0] head;
    assign head = wide[XW-1:OUT_W-1];

    always_comb begin
        if (head == '0 || head == '1) begin
            dout = wide[OUT_W-1:0];
        end else if (wide[XW-1]) begin
            dout = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            dout = {1'b0, {(OUT_W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/sinc4_decim.sv
module sinc4_decim #(
    parameter int DEC_LOG2 = 11,
    parameter int ORDER    = 4,
    parameter int OUT_W    = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_ce,
    input  logic             mod_bit,
    input  logic             run_mode,
    input  logic             restart,
    output logic             res_valid,
    output logic [OUT_W-1:0] res_data
);
    import sinc4_pkg::*;

    localparam int FS_LOG2 = ORDER * DEC_LOG2;
    localparam int W       = FS_LOG2 + 2;
    localparam int SW      = $clog2(ORDER);

    typedef struct packed {
        logic [DEC_LOG2-1:0] phase;
        logic [SW-1:0]       settle;
        logic                valid;
        logic [OUT_W-1:0]    data;
    } ctl_st_t;

    ctl_st_t          st_q, st_d;
    logic             take, dec, emit, clr_all;
    logic [W-1:0]     integ_tail, comb_out;
    logic [OUT_W-1:0] fmt_out;
    run_mode_e        mode;

    assign mode = run_mode_e'(run_mode);

    always_comb begin
        take    = mod_ce && !restart;
        dec     = take && (st_q.phase == '1);
        emit    = dec && (st_q.settle == SW'(ORDER - 1));
        clr_all = restart || (emit && mode == RUN_ONESHOT);

        st_d       = st_q;
        st_d.valid = emit;
        if (emit) st_d.data = fmt_out;
        if (clr_all) begin
            st_d.phase  = '0;
            st_d.settle = '0;
        end else begin
            if (take) st_d.phase = st_q.phase + 1'b1;
            if (dec && st_q.settle != SW'(ORDER - 1)) st_d.settle = st_q.settle + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sinc4_integ #(.ORDER(ORDER), .W(W)) u_integ (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .step(take),
        .bit_in(mod_bit), .tail_nx(integ_tail)
    );

    sinc4_comb #(.ORDER(ORDER), .W(W)) u_comb (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .load(dec),
        .din(integ_tail), .dout(comb_out)
    );

    sinc4_fmt #(.W(W), .FS_LOG2(FS_LOG2), .OUT_W(OUT_W)) u_fmt (
        .din(comb_out), .dout(fmt_out)
    );

    assign res_valid = st_q.valid;
    assign res_data  = st_q.data;
endmodule

// File: rtl/sinc4_decim_chk.sv
module sinc4_decim_chk #(
    parameter int DEC_LOG2 = 11,
    parameter int ORDER    = 4,
    parameter int OUT_W    = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mod_ce,
    input logic             run_mode,
    input logic             restart,
    input logic             res_valid,
    input logic [OUT_W-1:0] res_data
);
    localparam int CW = DEC_LOG2 + $clog2(ORDER) + 2;
    localparam logic [CW-1:0] SPAN = CW'(ORDER) << DEC_LOG2;

    logic [CW-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       seen_q <= '0;
        else if (restart) seen_q <= '0;
        else              seen_q <= (res_valid ? '0 : seen_q) + (mod_ce ? CW'(1) : CW'(0));
    end

    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !res_valid);

    a_r3_oneshot_span: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !run_mode) |-> seen_q == SPAN);

    a_r5_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(mod_ce) && !$past(restart)));

    a_r6_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !res_valid);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_data));
endmodule

bind sinc4_decim sinc4_decim_chk #(.DEC_LOG2(DEC_LOG2), .ORDER(ORDER), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mod_ce(mod_ce), .run_mode(run_mode),
    .restart(restart), .res_valid(res_valid), .res_data(res_data)
);

// File: tb/sim_sinc4_decim.sv
`timescale 1ns/1ps
module sim_sinc4_decim;
    localparam int L    = 2;
    localparam int R    = 1 << L;
    localparam int ORD  = 4;
    localparam int SPAN = ORD * R;
    localparam int HL   = ORD * (R - 1) + 1;
    localparam int UPSH = 23 - ORD * L;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0;
    logic        din = 1'b0;
    logic        mode = 1'b0;
    logic        rs = 1'b0;
    logic        vld;
    logic [23:0] dat;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    int h [HL];
    int xs [512];
    logic [15:0] lf = 16'hACE1;

    always #2 clk = ~clk;

    sinc4_decim #(.DEC_LOG2(L), .ORDER(ORD), .OUT_W(24)) u0 (
        .clk(clk), .rst_n(rst_n), .mod_ce(ce), .mod_bit(din),
        .run_mode(mode), .restart(rs), .res_valid(vld), .res_data(dat)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int fir(input int n);
        int s = 0;
        for (int k = 0; k < HL; k++) if (n - k >= 0) s += h[k] * xs[n-k];
        return s;
    endfunction

    // R7 scaling then R8 clamp, computed arithmetically
    function automatic logic [23:0] fmt(input int v);
        longint s = longint'(v) * (longint'(1) << UPSH);
        if (s > 64'sd8388607)  return 24'h7FFFFF;
        if (s < -64'sd8388608) return 24'h800000;
        return s[23:0];
    endfunction

    function automatic logic nxbit();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[0];
    endfunction

    task automatic push(input logic b);
        @(negedge clk); ce = 1'b1; din = b;
        @(posedge clk); #1; ce = 1'b0;
    endtask

    task automatic idle(input int n, input logic junk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ce = 1'b0; din = junk;
            @(posedge clk); #1;
            chk("R5 idle valid", 32'(vld), 32'd0);
        end
    endtask

    task automatic do_restart();
        @(negedge clk); rs = 1'b1; ce = 1'b1; din = 1'b1;
        @(posedge clk); #1; rs = 1'b0; ce = 1'b0;
        chk("R6 restart valid", 32'(vld), 32'd0);
    endtask

    // one full one-shot conversion from bits in xs[0..SPAN-1]
    task automatic oneshot_conv(input string tag);
        for (int j = 0; j < SPAN; j++) begin
            push(xs[j] > 0);
            chk("R3 valid timing", 32'(vld), 32'(j == SPAN - 1));
        end
        chk(tag, 32'(dat), 32'(fmt(fir(SPAN - 1))));
    endtask

    initial begin
        int tmp [HL];
        int len;
        logic [23:0] held;
        for (int i = 0; i < HL; i++) h[i] = 0;
        h[0] = 1; len = 1;
        repeat (ORD) begin
            for (int i = 0; i < HL; i++) tmp[i] = 0;
            for (int i = 0; i < len; i++)
                for (int j = 0; j < R; j++) tmp[i+j] += h[i];
            len += R - 1;
            h = tmp;
        end

        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset valid", 32'(vld), 32'd0);
        chk("R1 reset data", 32'(dat), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 post-reset valid", 32'(vld), 32'd0);

        // Exhaustive one-shot sweep over all weighted bit patterns (R2, R3, R7, R8)
        mode = 1'b0;
        do_restart();
        for (int p = 0; p < (1 << (SPAN - 3)); p++) begin
            int v;
            for (int j = 0; j < SPAN; j++) begin
                logic b;
                b = (j < 3) ? p[j] : p[j-3];
                xs[j] = b ? 1 : -1;
            end
            v = fir(SPAN - 1);
            if (p == 0)
                oneshot_conv("R7 all-zero scale");
            else if (v * (1 << UPSH) > 8388607)
                oneshot_conv("R8 saturation");
            else
                oneshot_conv("R2 sinc response");
        end
        chk("R8 all-ones word", 32'(dat), 32'h007FFFFF);

        // R9: data held, valid low between results
        held = dat;
        idle(4, 1'b0);
        chk("R9 data held", 32'(dat), 32'(held));

        // R5: gaps in mod_ce with toggling bit do not disturb the conversion
        for (int j = 0; j < SPAN; j++) xs[j] = nxbit() ? 1 : -1;
        for (int j = 0; j < SPAN; j++) begin
            push(xs[j] > 0);
            if (j != SPAN - 1) begin
                chk("R5 no early valid", 32'(vld), 32'd0);
                idle(j % 3, xs[j] < 0);
            end
        end
        chk("R5 gapped valid", 32'(vld), 32'd1);
        chk("R5 gapped data", 32'(dat), 32'(fmt(fir(SPAN - 1))));

        // R6: restart in the middle of a conversion
        for (int j = 0; j < 7; j++) push(nxbit());
        do_restart();
        for (int j = 0; j < SPAN; j++) xs[j] = nxbit() ? 1 : -1;
        oneshot_conv("R6 after restart");

        // R4: free-running cadence and history
        mode = 1'b1;
        do_restart();
        for (int n = 0; n < SPAN + 12 * R; n++) begin
            logic ev;
            xs[n] = nxbit() ? 1 : -1;
            push(xs[n] > 0);
            ev = ((n + 1) >= SPAN) && (((n + 1) % R) == 0);
            chk("R4 valid cadence", 32'(vld), 32'(ev));
            if (ev) chk("R4 history data", 32'(dat), 32'(fmt(fir(n))));
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule